// File: doc/BRIEF.md
# Prioritized interrupt line multiplexer

This block routes interrupt requests from four peripheral sources onto the four interrupt inputs of a small CPU. The sources are a general-purpose I/O port, a serial port, a timer and a second timer. Each source delivers single-cycle request pulses. For every source, software controls two things: whether its requests are accepted, and which CPU line it drives. The line is chosen through a packed 2-bit priority field. An accepted request latches a pending bit. The pending bit stays set until software acknowledges it by writing a zero into that bit position.

Software reaches the block through a plain 8-bit register bus: an address offset, a write strobe, write data, and combinational read data. There are four registers: the source enables, the packed priority fields, a reserved location, and the pending status. Each register answers only at its own offset. Any other offset reads as zero and ignores writes. The CPU lines are the OR of the pending bits routed to each line. They follow the pending state with no register in between.

Top module: `irq_router`

## Requirements
- R1: After reset the enable, priority and pending registers are all zero, every offset reads 0 and all cpu_irq lines are low.
- R2: Offset 0 is the enable mask. Bit 0 enables the I/O port, bit 1 the serial port, bit 2 the timer and bit 3 the second timer. A write stores bits 3:0, and bits 7:4 always read 0.
- R3: Offset 1 holds the four priority fields and reads back as written. Bits 1:0 belong to the I/O port, 3:2 to the serial port, 5:4 to the timer and 7:6 to the second timer.
- R4: Offset 2 is reserved. It always reads 0, and writes to it change no register.
- R5: A pulse on src_pulse[i] while enable bit i is 1 sets pending bit i at that clock edge. Offset 3 shows the pending bits in the enable-mask bit order, with bits 7:4 reading 0.
- R6: A pulse from a source whose enable bit is 0 never sets its pending bit.
- R7: Writing 0 to pending bit i at offset 3 clears it at that edge. Writing 1 leaves the bit unchanged.
- R8: If a pulse from an enabled source arrives in the same cycle as a write of 0 to its pending bit, the bit ends up set.
- R9: cpu_irq[n] is high exactly when at least one pending bit is set whose priority field equals n. It changes in the same cycle as the pending state.
- R10: Offsets 4 and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| src_pulse | input | 4 | Single-cycle request pulses: bit 0 I/O port, 1 serial, 2 timer, 3 second timer |
| cpu_irq | output | 4 | CPU interrupt lines |

## Verification
The bench uses the default parameters: four sources, four lines, 8-bit data and a 4-bit offset. With these values the whole register map is packed into one byte, and every source-to-line mapping can be reached. Because the offset is wider than the four live registers, offsets 4 to 15 are addressable, so the exact-address decoding can be exercised. Random writes to all offsets are mixed with random request pulses. This exercises acknowledges that race with new requests, disabled sources, and several sources sharing one line.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // Register offsets; software depends on this placement.
  localparam int OFS_ENABLE = 0;
  localparam int OFS_PRIO   = 1;
  localparam int OFS_RSVD   = 2;
  localparam int OFS_PEND   = 3;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_enable_i,
  input  logic                      wr_prio_i,
  input  logic [NUM_SRC*PRIO_W-1:0] wdata_i,
  output logic [NUM_SRC-1:0]        enable_o,
  output logic [NUM_SRC*PRIO_W-1:0] prio_o
);
  localparam int PF_W = NUM_SRC * PRIO_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o <= '0;
      prio_o   <= '0;
    end else begin
      if (wr_enable_i) enable_o <= wdata_i[NUM_SRC-1:0];
      if (wr_prio_i)   prio_o   <= wdata_i[PF_W-1:0];
    end
  end

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable_i |=> $stable(enable_o)); // R2
  AST_PRIO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_prio_i |=> $stable(prio_o)); // R3
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic               ack_we_i,
  input  logic [NUM_SRC-1:0] ack_data_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] accept;
  logic [NUM_SRC-1:0] keep_mask;

  // Only enabled sources may raise a pending bit.
  assign accept = src_i & enable_i;
  // A write keeps the bits written as 1 and drops those written as 0.
  assign keep_mask = ack_we_i ? ack_data_i : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & keep_mask) | accept;
  end

  AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept != '0) |=> ((pend_o & $past(accept)) == $past(accept))); // R5
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(src_i & enable_i)) == '0)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we_i && src_i == '0) |=> ((pend_o & ~$past(ack_data_i)) == '0)); // R7
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we_i && src_i == '0) |=> $stable(pend_o)); // R7
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map #(
  parameter int NUM_SRC   = 4,
  parameter int NUM_LINES = 4,
  parameter int PRIO_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic [NUM_LINES-1:0]      irq_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_SRC-1:0] routed;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign routed[s] = (prio_i[s*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
    assign irq_o[l] = |(pend_i & routed);
  end

  AST_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> (irq_o == '0)); // R9
  AST_LINES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_o) <= $countones(pend_i)); // R9
  AST_LINES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i != '0) |-> (irq_o != '0)); // R9
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_SRC   = 4,
  parameter int NUM_LINES = 4,  // at least 2
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]   src_pulse,
  output logic [NUM_LINES-1:0] cpu_irq
);
  import irq_router_pkg::*;

  localparam int PRIO_W = $clog2(NUM_LINES);
  localparam int PF_W   = NUM_SRC * PRIO_W;

  logic               sel_enable, sel_prio, sel_rsvd, sel_pend;
  logic [NUM_SRC-1:0] enable_q;
  logic [PF_W-1:0]    prio_q;
  logic [NUM_SRC-1:0] pend_q;

  assign sel_enable = (bus_addr == ADDR_W'(OFS_ENABLE));
  assign sel_prio   = (bus_addr == ADDR_W'(OFS_PRIO));
  assign sel_rsvd   = (bus_addr == ADDR_W'(OFS_RSVD));
  assign sel_pend   = (bus_addr == ADDR_W'(OFS_PEND));

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_enable_i (bus_we && sel_enable),
    .wr_prio_i   (bus_we && sel_prio),
    .wdata_i     (bus_wdata[PF_W-1:0]),
    .enable_o    (enable_q),
    .prio_o      (prio_q)
  );

  irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_pulse),
    .enable_i   (enable_q),
    .ack_we_i   (bus_we && sel_pend),
    .ack_data_i (bus_wdata[NUM_SRC-1:0]),
    .pend_o     (pend_q)
  );

  irq_line_map #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_q),
    .prio_i (prio_q),
    .irq_o  (cpu_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_enable)    bus_rdata = DATA_W'(enable_q);
    else if (sel_prio) bus_rdata = DATA_W'(prio_q);
    else if (sel_pend) bus_rdata = DATA_W'(pend_q);
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rsvd |-> (bus_rdata == '0)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(OFS_PEND)) |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] src_pulse = '0;
  logic [3:0] cpu_irq;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_en = '0;
  logic [7:0] m_prio = '0;
  logic [3:0] m_pend = '0;

  always #10 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
    .cpu_irq(cpu_irq)
  );

  function automatic logic [3:0] exp_lines(logic [3:0] pend, logic [7:0] prio);
    logic [3:0] r = '0;
    for (int s = 0; s < 4; s++)
      if (pend[s]) r[prio[s*2 +: 2]] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] exp_read(int a);
    case (a)
      0: return {4'b0, m_en};
      1: return m_prio;
      3: return {4'b0, m_pend};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle, update the model at the edge, then check away from the edge.
  task automatic step(int a, logic we, logic [7:0] wd, logic [3:0] pulse, string req);
    logic [3:0] nxt;
    bus_addr = 4'(a); bus_we = we; bus_wdata = wd; src_pulse = pulse;
    @(posedge clk);
    nxt = m_pend;
    if (we && a == 3) nxt = nxt & wd[3:0];
    nxt = nxt | (pulse & m_en);
    if (we && a == 0) m_en = wd[3:0];
    if (we && a == 1) m_prio = wd;
    m_pend = nxt;
    #2;
    bus_we = 1'b0; src_pulse = '0;
    chk(req, {4'b0, cpu_irq}, {4'b0, exp_lines(m_pend, m_prio)});
  endtask

  task automatic check_reads(string req);
    for (int a = 0; a < 16; a++) begin
      bus_addr = 4'(a);
      #1;
      chk((req == "") ? read_tag(a) : req, bus_rdata, exp_read(a));
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    check_reads("R1");
    chk("R1", {4'b0, cpu_irq}, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R6: disabled sources do not latch
    step(0, 0, 0, 4'hF, "R6");
    bus_addr = 4'd3; #1; chk("R6", bus_rdata, 8'h00);

    // R2 / R3 configuration, upper enable bits dropped
    step(0, 1, 8'hFF, 4'h0, "R2");
    check_reads("R2");
    step(1, 1, 8'b11_10_01_00, 4'h0, "R3");
    check_reads("");

    // R5 / R9: I/O port to line 0, timer to line 2
    step(2, 0, 0, 4'b0101, "R9");
    bus_addr = 4'd3; #1; chk("R5", bus_rdata, 8'h05);
    chk("R9", {4'b0, cpu_irq}, 8'h05);

    // R7: writing ones leaves bits, zero clears
    step(3, 1, 8'hFF, 4'h0, "R7");
    bus_addr = 4'd3; #1; chk("R7", bus_rdata, 8'h05);
    step(3, 1, 8'hFE, 4'h0, "R7");
    bus_addr = 4'd3; #1; chk("R7", bus_rdata, 8'h04);

    // R8: request during acknowledge wins
    step(3, 1, 8'h00, 4'b0100, "R8");
    bus_addr = 4'd3; #1; chk("R8", bus_rdata, 8'h04);

    // R9: all sources share line 0
    step(1, 1, 8'h00, 4'b1000, "R9");
    chk("R9", {4'b0, cpu_irq}, 8'h01);

    // R4 / R10: writes to reserved and unmapped offsets are ignored
    step(2, 1, 8'hFF, 4'h0, "R4");
    step(9, 1, 8'h00, 4'h0, "R10");
    step(15, 1, 8'hAA, 4'h0, "R10");
    check_reads("");

    // Random traffic against the model
    for (int i = 0; i < 500; i++) begin
      int a = ($urandom % 3 == 0) ? int'($urandom % 16) : int'($urandom % 4);
      step(a, 1'($urandom), 8'($urandom), 4'($urandom), "R9");
      if (i % 25 == 0) check_reads("");
      else begin
        bus_addr = 4'd3; #1; chk("R5", bus_rdata, exp_read(3));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule